// File: doc/BRIEF.md
# Signed Saturating Add/Subtract Unit

This block is a 32-bit signed arithmetic unit whose results never wrap. It accepts one operation per cycle. The operation is either an add or a subtract. Its operands come from two register values or from one register value and a sign-extended immediate. When the exact signed result falls outside the representable range, the output is pinned to the nearest limit. The block then raises an overflow flag and a sticky saturation flag.

The pipeline feeds in the current sticky flag with each operation and takes the new one back. Once saturation has been seen, it therefore stays recorded until the surrounding logic clears it. Results and flags are registered and appear one cycle after the operation is presented. Register file access and operand forwarding belong to the surrounding pipeline.

Top module: `satalu`

## Requirements
- R1: Operation code 0 produces the saturated value of reg_b + reg_a.
- R2: Operation code 1 produces the saturated value of reg_b plus the 5-bit immediate, with the immediate sign-extended (bit 4 is the sign).
- R3: Operation code 2 produces the saturated value of reg_b − reg_a.
- R4: Operation code 3 produces the saturated value of reg_a − reg_b (reverse subtract).
- R5: Operation code 4 produces the saturated value of reg_a minus the 16-bit immediate, with the immediate sign-extended (bit 15 is the sign).
- R6: A result above the signed maximum is output as 7FFFFFFFh, and one below the signed minimum as 80000000h. In both cases flag_ov is 1. flag_ov is 0 whenever no clamping occurs.
- R7: flag_sat equals sat_in OR the clamp condition, so an operation never clears it.
- R8: flag_s is bit 31 of the clamped result. flag_z is 1 exactly when the clamped result is zero.
- R9: For additions, flag_cy is the unsigned carry out of the unclamped sum. For subtractions, it is the unsigned borrow, which is 1 when the minuend is below the subtrahend as unsigned values.
- R10: The result and flags of an operation accepted with valid_in=1 appear on the outputs after the next rising clock edge, with valid_out=1. While valid_in=0, valid_out goes to 0 and the result and flags hold their last values.
- R11: After reset, valid_out, the result and all flags are 0.
- R12: Operation codes 5, 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (see R1–R5, R12) |
| reg_a | input | 32 | First register operand |
| reg_b | input | 32 | Second register operand |
| imm_short | input | 5 | Short immediate, signed |
| imm_long | input | 16 | Long immediate, signed |
| sat_in | input | 1 | Current sticky saturation flag |
| valid_out | output | 1 | Result registered this cycle |
| result | output | 32 | Clamped result |
| flag_cy | output | 1 | Carry / borrow of the unclamped operation |
| flag_ov | output | 1 | Clamping occurred |
| flag_s | output | 1 | Sign of the clamped result |
| flag_z | output | 1 | Clamped result is zero |
| flag_sat | output | 1 | Updated sticky saturation flag |

## Verification
The hardest cases are the ones where carry and overflow disagree. One example is a reverse subtract of the signed minimum from a small positive value. It clamps high, yet it borrows. Another is a short negative immediate added to the signed minimum. It clamps low and still carries. The stimulus constructs these operands directly for each operation code. It pairs every clamp with sat_in both low and high, so the sticky path and the clamp path are seen separately. A hold phase with valid_in low and scrambled operands confirms that the registered outputs do not move.

// File: rtl/satalu_pkg.sv
package satalu_pkg;
   typedef enum logic [2:0] {
      OP_ADD    = 3'd0,
      OP_ADDI_S = 3'd1,
      OP_SUB    = 3'd2,
      OP_RSUB   = 3'd3,
      OP_SUBI_L = 3'd4
   } op_e;

   typedef struct packed {
      logic cy;
      logic ov;
      logic s;
      logic z;
      logic sat;
   } flags_t;
endpackage

// File: rtl/satalu_opsel.sv
module satalu_opsel
   import satalu_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_S = 5,
   parameter int IMM_L = 16
) (
   input  logic [2:0]       op,
   input  logic [W-1:0]     reg_a,
   input  logic [W-1:0]     reg_b,
   input  logic [IMM_S-1:0] imm_short,
   input  logic [IMM_L-1:0] imm_long,
   output logic [W-1:0]     opnd_x,
   output logic [W-1:0]     opnd_y,
   output logic             do_sub
);
   localparam int PAD_S = W - IMM_S;
   localparam int PAD_L = W - IMM_L;

   logic [W-1:0] sx_short, sx_long;

   assign sx_short = {{PAD_S{imm_short[IMM_S-1]}}, imm_short};
   assign sx_long  = {{PAD_L{imm_long[IMM_L-1]}}, imm_long};

   always_comb begin
      opnd_x = reg_b;
      opnd_y = reg_a;
      do_sub = 1'b0;
      case (op)
         OP_ADDI_S: begin opnd_x = reg_b; opnd_y = sx_short; do_sub = 1'b0; end
         OP_SUB:    begin opnd_x = reg_b; opnd_y = reg_a;    do_sub = 1'b1; end
         OP_RSUB:   begin opnd_x = reg_a; opnd_y = reg_b;    do_sub = 1'b1; end
         OP_SUBI_L: begin opnd_x = reg_a; opnd_y = sx_long;  do_sub = 1'b1; end
         default:   begin opnd_x = reg_b; opnd_y = reg_a;    do_sub = 1'b0; end
      endcase
   end
endmodule

// File: rtl/satalu_addsub.sv
module satalu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] opnd_x,
   input  logic [W-1:0] opnd_y,
   input  logic         do_sub,
   output logic [W-1:0] raw_sum,
   output logic         raw_cy,
   output logic         raw_ov
);
   localparam int MSB = W - 1;

   logic [W-1:0] y_eff;
   logic [W:0]   wide;

   assign y_eff   = do_sub ? ~opnd_y : opnd_y;
   assign wide    = {1'b0, opnd_x} + {1'b0, y_eff} + {{W{1'b0}}, do_sub};
   assign raw_sum = wide[W-1:0];
   // carry out of the inverted-operand add is the complement of the borrow
   assign raw_cy  = wide[W] ^ do_sub;
   assign raw_ov  = (opnd_x[MSB] == y_eff[MSB]) && (raw_sum[MSB] != opnd_x[MSB]);
endmodule

// File: rtl/satalu_clamp.sv
module satalu_clamp
   import satalu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] raw_sum,
   input  logic         raw_cy,
   input  logic         raw_ov,
   input  logic         sat_in,
   output logic [W-1:0] clamped,
   output flags_t       flags
);
   localparam int MSB = W - 1;
   localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

   always_comb begin
      // a wrapped sum with its sign bit set came from a positive overflow
      if (raw_ov) clamped = raw_sum[MSB] ? S_MAX : S_MIN;
      else        clamped = raw_sum;
      flags.cy  = raw_cy;
      flags.ov  = raw_ov;
      flags.s   = clamped[MSB];
      flags.z   = (clamped == '0);
      flags.sat = sat_in | raw_ov;
   end
endmodule

// File: rtl/satalu.sv
module satalu
   import satalu_pkg::*;
#(
   parameter int W       = 32,
   parameter int IMM_S   = 5,
   parameter int IMM_L   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [2:0]        op,
   input  logic [W-1:0]      reg_a,
   input  logic [W-1:0]      reg_b,
   input  logic [IMM_S-1:0]  imm_short,
   input  logic [IMM_L-1:0]  imm_long,
   input  logic              sat_in,
   output logic              valid_out,
   output logic [W-1:0]      result,
   output logic              flag_cy,
   output logic              flag_ov,
   output logic              flag_s,
   output logic              flag_z,
   output logic              flag_sat
);
   localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

   if (W < 2)          begin : g_chk_w  $error("W must be at least 2");      end
   if (IMM_S >= W)     begin : g_chk_s  $error("IMM_S must be below W");     end
   if (IMM_L >= W)     begin : g_chk_l  $error("IMM_L must be below W");     end
   if (IMM_S < 1 || IMM_L < 1) begin : g_chk_i $error("immediates need width"); end

   logic [W-1:0] opnd_x, opnd_y, raw_sum, clamped;
   logic         do_sub, raw_cy, raw_ov;
   flags_t       nxt_flags;

   satalu_opsel #(.W(W), .IMM_S(IMM_S), .IMM_L(IMM_L)) u_opsel (
      .op(op), .reg_a(reg_a), .reg_b(reg_b),
      .imm_short(imm_short), .imm_long(imm_long),
      .opnd_x(opnd_x), .opnd_y(opnd_y), .do_sub(do_sub)
   );

   satalu_addsub #(.W(W)) u_addsub (
      .opnd_x(opnd_x), .opnd_y(opnd_y), .do_sub(do_sub),
      .raw_sum(raw_sum), .raw_cy(raw_cy), .raw_ov(raw_ov)
   );

   satalu_clamp #(.W(W)) u_clamp (
      .raw_sum(raw_sum), .raw_cy(raw_cy), .raw_ov(raw_ov),
      .sat_in(sat_in), .clamped(clamped), .flags(nxt_flags)
   );

   if (OUT_REG) begin : g_reg
      logic [W-1:0] res_q;
      flags_t       flg_q;
      logic         vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= valid_in;
            if (valid_in) begin
               res_q <= clamped;
               flg_q <= nxt_flags;
            end
         end
      end

      assign valid_out = vld_q;
      assign result    = res_q;
      assign flag_cy   = flg_q.cy;
      assign flag_ov   = flg_q.ov;
      assign flag_s    = flg_q.s;
      assign flag_z    = flg_q.z;
      assign flag_sat  = flg_q.sat;

      a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> valid_out);
      a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> ($stable(result) && !valid_out));
      a_r7_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && sat_in) |=> flag_sat);
      a_r6_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_out && flag_ov && !flag_s) |-> (result == S_MAX));
      a_r6_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_out && flag_ov && flag_s) |-> (result == S_MIN));
      a_r7_ov_sets_sat: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_out && flag_ov) |-> flag_sat);
   end else begin : g_comb
      assign valid_out = valid_in;
      assign result    = clamped;
      assign flag_cy   = nxt_flags.cy;
      assign flag_ov   = nxt_flags.ov;
      assign flag_s    = nxt_flags.s;
      assign flag_z    = nxt_flags.z;
      assign flag_sat  = nxt_flags.sat;
   end
endmodule

// File: tb/satalu_tb.sv
`timescale 1ns/1ps
module satalu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [2:0]  op = '0;
   logic [31:0] reg_a = '0, reg_b = '0;
   logic [4:0]  imm_short = '0;
   logic [15:0] imm_long = '0;
   logic        sat_in = 1'b0;
   logic        valid_out, flag_cy, flag_ov, flag_s, flag_z, flag_sat;
   logic [31:0] result;

   always #2 clk = ~clk;

   satalu u_dut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
      .reg_a(reg_a), .reg_b(reg_b), .imm_short(imm_short), .imm_long(imm_long),
      .sat_in(sat_in), .valid_out(valid_out), .result(result),
      .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s),
      .flag_z(flag_z), .flag_sat(flag_sat)
   );

   typedef struct {
      logic [31:0] res;
      logic [4:0]  flg;   // cy ov s z sat
      string       tag;
   } exp_t;

   exp_t  sb[$];
   int    n_run = 0, n_fail = 0;
   bit    done = 0;
   exp_t  last_exp;

   function automatic exp_t model(input logic [2:0] o, input logic [31:0] a,
                                  input logic [31:0] b, input logic [4:0] is,
                                  input logic [15:0] il, input logic si, input string tg);
      exp_t e;
      logic [31:0] x, y;
      bit sub;
      longint ex, lim_hi, lim_lo;
      logic [32:0] usum;
      bit cy, ov;
      lim_hi = 64'sh7FFFFFFF;
      lim_lo = -64'sh80000000;
      case (o)
         3'd1: begin x = b; y = {{27{is[4]}}, is}; sub = 0; end
         3'd2: begin x = b; y = a; sub = 1; end
         3'd3: begin x = a; y = b; sub = 1; end
         3'd4: begin x = a; y = {{16{il[15]}}, il}; sub = 1; end
         default: begin x = b; y = a; sub = 0; end
      endcase
      ex = sub ? (longint'($signed(x)) - longint'($signed(y)))
               : (longint'($signed(x)) + longint'($signed(y)));
      usum = {1'b0, x} + {1'b0, y};
      cy = sub ? (x < y) : usum[32];
      ov = 0;
      if (ex > lim_hi) begin ex = lim_hi; ov = 1; end
      if (ex < lim_lo) begin ex = lim_lo; ov = 1; end
      e.res = ex[31:0];
      e.flg = {cy, ov, e.res[31], (e.res == 0), si | ov};
      e.tag = tg;
      return e;
   endfunction

   task automatic drive(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] is, input logic [15:0] il, input logic si,
                        input string tg);
      @(negedge clk);
      op = o; reg_a = a; reg_b = b; imm_short = is; imm_long = il; sat_in = si;
      valid_in = 1'b1;
      last_exp = model(o, a, b, is, il, si, tg);
      sb.push_back(last_exp);
   endtask

   task automatic check(input bit ok, input string tg, input logic [63:0] act,
                        input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   // monitor: compare each registered result against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && valid_out) begin
            if (sb.size() == 0) begin
               check(0, "R10 unexpected valid_out", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(result == e.res && {flag_cy, flag_ov, flag_s, flag_z, flag_sat} == e.flg,
                     e.tag, {27'd0, flag_cy, flag_ov, flag_s, flag_z, flag_sat, result},
                     {27'd0, e.flg, e.res});
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(valid_out == 0 && result == 0 &&
            {flag_cy, flag_ov, flag_s, flag_z, flag_sat} == 0,
            "R11 reset state", {flag_sat, valid_out, result}, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      drive(3'd0, 32'd7, 32'd5, 5'd0, 16'd0, 0, "R1 add small");
      drive(3'd0, 32'd1, 32'h7FFFFFFF, 5'd0, 16'd0, 0, "R1 R6 add clamp high");
      drive(3'd0, 32'hFFFFFFFF, 32'h80000000, 5'd0, 16'd0, 0, "R6 R9 add clamp low with carry");
      drive(3'd0, 32'hFFFFFFFF, 32'd1, 5'd0, 16'd0, 0, "R8 R9 add zero with carry");
      drive(3'd1, 32'd0, 32'd3, 5'h10, 16'd0, 0, "R2 imm5 negative");
      drive(3'd1, 32'd0, 32'h80000000, 5'h1F, 16'd0, 0, "R2 R6 imm5 clamp low");
      drive(3'd1, 32'd0, 32'h7FFFFFF0, 5'h0F, 16'd0, 1, "R2 R7 imm5 sticky sat");
      drive(3'd2, 32'd10, 32'd10, 5'd0, 16'd0, 0, "R3 R8 sub zero");
      drive(3'd2, 32'd1, 32'd0, 5'd0, 16'd0, 0, "R3 R9 sub borrow");
      drive(3'd2, 32'd1, 32'h80000000, 5'd0, 16'd0, 0, "R3 R6 sub clamp low");
      drive(3'd3, 32'd1, 32'h80000000, 5'd0, 16'd0, 0, "R4 R6 rsub clamp high");
      drive(3'd3, 32'd9, 32'd4, 5'd0, 16'd0, 1, "R4 R7 rsub sticky");
      drive(3'd4, 32'h7FFFFFFF, 32'd0, 5'd0, 16'h8000, 0, "R5 R6 subi clamp high");
      drive(3'd4, 32'd100, 32'd0, 5'd0, 16'd100, 0, "R5 R8 subi zero");
      drive(3'd4, 32'd5, 32'd0, 5'd0, 16'hFFFF, 0, "R5 R9 subi negative imm");
      drive(3'd5, 32'd2, 32'd3, 5'd7, 16'd9, 0, "R12 code5 as add");
      drive(3'd6, 32'd1, 32'h7FFFFFFF, 5'd1, 16'd1, 0, "R12 code6 as add");
      drive(3'd7, 32'hFFFFFFFE, 32'd1, 5'd2, 16'd2, 1, "R12 code7 as add");

      // R10 hold: drop valid, scramble inputs
      @(negedge clk);
      valid_in = 1'b0; op = 3'd2; reg_a = 32'h12345678; reg_b = 32'h9ABCDEF0;
      sat_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(valid_out == 0 && result == last_exp.res &&
            {flag_cy, flag_ov, flag_s, flag_z, flag_sat} == last_exp.flg,
            "R10 hold while idle", {valid_out, result}, {1'b0, last_exp.res});
      check(sb.size() == 0, "R10 all results produced", sb.size(), 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule